// File: doc/BRIEF.md
# Double-Write Shadowed Control Register

This block is a single control register that software must write twice, with the same data, before the new value takes effect. The first write is parked in a staged copy and a staged-valid flag is raised. A second write with equal data moves the value into the committed register and clears the flag. A second write with different data is rejected and flagged as an update error. The staged copy and the flag are left as they were, so a later write with the original data can still complete the commit. A bus read returns the committed value and abandons any pending first write.

Downstream logic sees the committed value on a side-band output, and sampling that output has no effect on the staged state. Three single-cycle status pulses report each accepted write as staged, committed or update error. Update errors also set a sticky error bit. The committed value has a twin copy held in bitwise-inverted form. If the two copies ever stop being exact complements, a sticky storage-error output is raised.

Top module: `twin_write_reg`

## Requirements
- R1: While reset is asserted, and after it is released, the committed value equals the parameter RESET_VAL, the read data equals RESET_VAL, and the staged-valid flag, all three status pulses, the sticky update-error bit and the storage-error output are 0.
- R2: A write while nothing is staged stores its data in the staged copy and sets the staged-valid flag. The committed value is unchanged, and stagedPulse is 1 in the cycle after the write.
- R3: A write while a value is staged, with data equal to the staged copy, loads that data into the committed value and clears the staged-valid flag. commitPulse is 1 in the cycle after the write, and the committed output shows the new data in that same cycle.
- R4: A write while a value is staged, with data different from the staged copy, is discarded. The committed value is unchanged, and errPulse is 1 in the cycle after the write.
- R5: After a mismatching write, the staged copy and the staged-valid flag are unchanged, so a later write equal to the original staged data commits it.
- R6: When rdEn is high in a cycle, rdData takes, in the following cycle, the committed value as it stands after any write of that same cycle. rdData holds its value in cycles that follow no read.
- R7: A read clears the staged-valid flag, so the next write after a read is treated as a first write and gives stagedPulse.
- R8: The obsValue output always equals the committed value, and its use never changes the staged state: a write pair with no read between them commits.
- R9: At most one of stagedPulse, commitPulse and errPulse is high in any cycle, and each pulse lasts one cycle unless another write follows at once.
- R10: errSticky becomes 1 in the cycle after an update error and stays 1 until reset.
- R11: The inverted copy is updated on every commit. storeErr rises and stays 1 when the committed value and the inverted copy are not exact complements, and it stays 0 in fault-free operation.
- R12: When a read and a write arrive in the same cycle, the write is processed first and gives its normal status pulse and commit. The staged-valid flag is then cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe |
| wrData | input | WIDTH | Bus write data |
| rdEn | input | 1 | Bus read strobe |
| rdData | output | WIDTH | Read data, registered and updated after each read |
| obsValue | output | WIDTH | Side-band committed value |
| stagedPulse | output | 1 | One-cycle pulse: a write was staged |
| commitPulse | output | 1 | One-cycle pulse: a write was committed |
| errPulse | output | 1 | One-cycle pulse: a second write did not match |
| errSticky | output | 1 | Sticky update error, cleared only by reset |
| storeErr | output | 1 | Sticky storage error from the inverted-copy check |

## Verification
The assertions assume that wrEn and rdEn are driven to known values in every cycle out of reset, and that wrData is known whenever wrEn is high. The bench changes its inputs only on the falling clock edge and never leaves them undriven. Random stimulus draws write data from a small pool of values, so that matching and mismatching second writes both occur often. Read and write strobes are drawn independently, so same-cycle reads and writes are covered. The storage-error path can be checked only for staying quiet, because no normal input can corrupt one copy alone.

// File: rtl/twin_write_pkg.sv
package twin_write_pkg;

  typedef struct packed {
    logic stageLoad;
    logic commitLoad;
    logic readCapture;
  } strobe_t;

endpackage

// File: rtl/twin_write_ctrl.sv
module twin_write_ctrl
  import twin_write_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic    rdEn,
  input  logic    dataMatch,
  output strobe_t strobe,
  output logic    stagedValid,
  output logic    stagedPulse,
  output logic    commitPulse,
  output logic    errPulse,
  output logic    errSticky
);

  logic mismatch;
  logic validNext;

  always_comb begin
    strobe.stageLoad   = wrEn && !stagedValid;
    strobe.commitLoad  = wrEn && stagedValid && dataMatch;
    strobe.readCapture = rdEn;
    mismatch           = wrEn && stagedValid && !dataMatch;
    validNext          = stagedValid;
    if (strobe.stageLoad)  validNext = 1'b1;
    if (strobe.commitLoad) validNext = 1'b0;
    // the write is settled first, then a same-cycle read drops the staged copy
    if (rdEn)              validNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagedValid <= 1'b0;
      stagedPulse <= 1'b0;
      commitPulse <= 1'b0;
      errPulse    <= 1'b0;
      errSticky   <= 1'b0;
    end else begin
      stagedValid <= validNext;
      stagedPulse <= strobe.stageLoad;
      commitPulse <= strobe.commitLoad;
      errPulse    <= mismatch;
      errSticky   <= errSticky | mismatch;
    end
  end

endmodule

// File: rtl/twin_write_data.sv
module twin_write_data
  import twin_write_pkg::*;
#(
  parameter int                 WIDTH     = 32,
  parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] committed,
  output logic [WIDTH-1:0] invCopy,
  output logic [WIDTH-1:0] stagedData,
  output logic [WIDTH-1:0] rdData,
  output logic             dataMatch,
  output logic             storeErr
);

  localparam logic [WIDTH-1:0] RESET_INV = ~RESET_VAL;

  logic [WIDTH-1:0] committedNext;
  logic             copyBroken;

  always_comb begin
    dataMatch     = (wrData == stagedData);
    committedNext = strobe.commitLoad ? wrData : committed;
    copyBroken    = (committed ^ invCopy) != {WIDTH{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      committed  <= RESET_VAL;
      invCopy    <= RESET_INV;
      stagedData <= '0;
      rdData     <= RESET_VAL;
      storeErr   <= 1'b0;
    end else begin
      if (strobe.stageLoad) stagedData <= wrData;
      if (strobe.commitLoad) begin
        committed <= wrData;
        invCopy   <= ~wrData;
      end
      if (strobe.readCapture) rdData <= committedNext;
      storeErr <= storeErr | copyBroken;
    end
  end

endmodule

// File: rtl/twin_write_reg.sv
module twin_write_reg
  import twin_write_pkg::*;
#(
  parameter int               WIDTH     = 32,
  parameter logic [WIDTH-1:0] RESET_VAL = 32'h0000_A5A5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] obsValue,
  output logic             stagedPulse,
  output logic             commitPulse,
  output logic             errPulse,
  output logic             errSticky,
  output logic             storeErr
);

  strobe_t          strobe;
  logic             stagedValid;
  logic             dataMatch;
  logic [WIDTH-1:0] invCopy;
  logic [WIDTH-1:0] stagedData;

  twin_write_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .rdEn        (rdEn),
    .dataMatch   (dataMatch),
    .strobe      (strobe),
    .stagedValid (stagedValid),
    .stagedPulse (stagedPulse),
    .commitPulse (commitPulse),
    .errPulse    (errPulse),
    .errSticky   (errSticky)
  );

  twin_write_data #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .committed  (obsValue),
    .invCopy    (invCopy),
    .stagedData (stagedData),
    .rdData     (rdData),
    .dataMatch  (dataMatch),
    .storeErr   (storeErr)
  );

endmodule

// File: rtl/twin_write_chk.sv
module twin_write_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [WIDTH-1:0] wrData,
  input logic             rdEn,
  input logic [WIDTH-1:0] rdData,
  input logic [WIDTH-1:0] obsValue,
  input logic             stagedPulse,
  input logic             commitPulse,
  input logic             errPulse,
  input logic             errSticky,
  input logic             storeErr,
  input logic             stagedValid,
  input logic [WIDTH-1:0] stagedData,
  input logic [WIDTH-1:0] invCopy
);

  a_r2_first_write_stages: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !stagedValid |=> stagedPulse && $stable(obsValue));

  a_r3_match_commits: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && stagedValid && (wrData == stagedData) |=> commitPulse && (obsValue == $past(wrData)));

  a_r4_mismatch_rejected: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && stagedValid && (wrData != stagedData) |=> errPulse && $stable(obsValue));

  a_r5_mismatch_keeps_stage: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && stagedValid && (wrData != stagedData) && !rdEn |=> stagedValid && $stable(stagedData));

  a_r6_read_returns_value: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdData == obsValue);

  a_r6_read_holds: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  a_r7_read_clears_stage: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> !stagedValid);

  a_r9_one_status: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stagedPulse, commitPulse, errPulse}));

  a_r10_sticky_holds: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);

  a_r10_sticky_follows_err: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> errSticky);

  a_r11_copies_complement: assert property (@(posedge clk) disable iff (!rstN)
    (obsValue ^ invCopy) == {WIDTH{1'b1}});

  a_r11_no_store_err: assert property (@(posedge clk) disable iff (!rstN)
    !storeErr);

endmodule

bind twin_write_reg twin_write_chk #(.WIDTH(WIDTH)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .rdEn        (rdEn),
  .rdData      (rdData),
  .obsValue    (obsValue),
  .stagedPulse (stagedPulse),
  .commitPulse (commitPulse),
  .errPulse    (errPulse),
  .errSticky   (errSticky),
  .storeErr    (storeErr),
  .stagedValid (stagedValid),
  .stagedData  (stagedData),
  .invCopy     (invCopy)
);

// File: tb/sim_twin_write_reg.sv
`timescale 1ns/1ps
module sim_twin_write_reg;

  localparam int          W    = 32;
  localparam logic [31:0] RVAL = 32'h0000_A5A5;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic         rdEn = 1'b0;
  logic [W-1:0] rdData, obsValue;
  logic         stagedPulse, commitPulse, errPulse, errSticky, storeErr;

  always #4 clk = ~clk;

  twin_write_reg #(.WIDTH(W), .RESET_VAL(RVAL)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .obsValue(obsValue), .stagedPulse(stagedPulse),
    .commitPulse(commitPulse), .errPulse(errPulse), .errSticky(errSticky),
    .storeErr(storeErr)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  logic [W-1:0] mCommit = RVAL;
  logic [W-1:0] mStage  = '0;
  bit           mValid  = 0;
  logic [W-1:0] mRd     = RVAL;
  bit mStP = 0, mCoP = 0, mErP = 0, mSticky = 0;

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    chk(tag, "obsValue", obsValue, mCommit);
    chk(tag, "rdData", rdData, mRd);
    chk(tag, "stagedPulse", W'(stagedPulse), W'(mStP));
    chk(tag, "commitPulse", W'(commitPulse), W'(mCoP));
    chk(tag, "errPulse", W'(errPulse), W'(mErP));
    chk(tag, "errSticky", W'(errSticky), W'(mSticky));
    chk(tag, "storeErr", W'(storeErr), '0);
  endtask

  // one cycle: drive at falling edge, model at rising edge, compare just after
  task automatic step(string tag, bit we, logic [W-1:0] wd, bit re);
    @(negedge clk);
    wrEn = we; wrData = wd; rdEn = re;
    @(posedge clk);
    mStP = 0; mCoP = 0; mErP = 0;
    if (we) begin
      if (!mValid) begin
        mStage = wd; mValid = 1; mStP = 1;
      end else if (wd == mStage) begin
        mCommit = wd; mValid = 0; mCoP = 1;
      end else begin
        mErP = 1; mSticky = 1;
      end
    end
    if (re) begin
      mValid = 0; mRd = mCommit;
    end
    #1;
    compareAll(tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 compareAll("R1");
    rstN = 1'b1;
    step("R1", 0, '0, 0);

    // R2 then R3: basic pair
    step("R2", 1, 32'h1234_5678, 0);
    step("R2", 0, '0, 0);
    step("R3", 1, 32'h1234_5678, 0);
    step("R8", 0, '0, 0);

    // R4, R5, R10: mismatch then retry with original data
    step("R2", 1, 32'hCAFE_0001, 0);
    step("R4", 1, 32'hCAFE_0002, 0);
    step("R10", 0, '0, 0);
    step("R5", 1, 32'hCAFE_0001, 0);
    step("R10", 0, '0, 0);

    // R6, R7: a read abandons a staged write
    step("R2", 1, 32'h0BAD_F00D, 0);
    step("R6", 0, '0, 1);
    step("R7", 1, 32'h0BAD_F00D, 0);
    step("R7", 1, 32'h0BAD_F00D, 0);
    step("R6", 0, '0, 1);
    step("R6", 0, '0, 0);

    // R12: read together with a commit, then with a first write
    step("R2", 1, 32'h5555_AAAA, 0);
    step("R12", 1, 32'h5555_AAAA, 1);
    step("R12", 1, 32'h7777_0000, 1);
    step("R12", 1, 32'h7777_0000, 0);
    step("R12", 1, 32'h7777_0000, 0);

    // R9: back-to-back writes of all kinds
    step("R9", 1, 32'h1, 0);
    step("R9", 1, 32'h2, 0);
    step("R9", 1, 32'h1, 0);
    step("R9", 1, 32'h3, 0);
    step("R11", 0, '0, 0);

    // random mix with a small value pool
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] v;
      v = 32'hF0F0_0000 | W'($urandom_range(0, 2));
      step("R9", ($urandom_range(0, 3) != 0), v, ($urandom_range(0, 5) == 0));
    end

    // R1 again: reset returns everything to the reset state
    @(negedge clk);
    rstN = 1'b0; wrEn = 0; rdEn = 0;
    @(posedge clk);
    mCommit = RVAL; mValid = 0; mRd = RVAL; mStP = 0; mCoP = 0; mErP = 0; mSticky = 0;
    #1 compareAll("R1");
    @(negedge clk);
    rstN = 1'b1;
    step("R2", 1, 32'h4444_4444, 0);
    step("R3", 1, 32'h4444_4444, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule